// File: doc/BRIEF.md
# Video Memory Write Timing Window

This block decides, for every processor write strobe aimed at video memory, whether that write lands or is lost. The outcome depends on two things at once: how many clock cycles have passed since the previous write strobe, and where the current frame stands. Frame position comes from an external cycle counter that returns to zero at each vertical interrupt.

Writes are sorted by their spacing into three classes. Close writes (up to 18 cycles apart) and wide writes (19 to 24 cycles apart) each have their own frame boundary, and the boundary also depends on the refresh standard. From that boundary until the end of the frame, writes of that class are lost. Isolated writes always land. In text mode nothing is ever lost.

A landed write is flagged and its byte is presented on the data output. A lost write is flagged and leaves the held byte alone, but it still counts as the latest write when the next spacing is measured.

Top module: `vram_write_window`

## Requirements
- R1: While reset is held, and on the first cycle after it, `wrCommit` and `wrDrop` are 0 and `vramData` is 0. Reset also leaves no previous write on record.
- R2: The outcome of a strobe sampled at a rising edge is visible from that edge until the next one. Exactly one of `wrCommit`/`wrDrop` is 1 for a strobe. Both are 0 when no strobe was sampled.
- R3: With `modeSel` = 2'b00 (text mode), every write commits, whatever its spacing or frame position.
- R4: In a graphic mode (`modeSel` != 2'b00) with `ntscSel` = 0, a write spaced 18 cycles or less after the previous one commits only if `frameCycle` < 27130.
- R5: In a graphic mode with `ntscSel` = 0, a write spaced 19 to 24 cycles after the previous one commits only if `frameCycle` < 27143.
- R6: With `ntscSel` = 1 in a graphic mode, the two boundaries are 15503 (spacing up to 18) and 15517 (spacing 19 to 24).
- R7: The first write after reset commits in every mode and frame position. So does any write more than 24 cycles after the previous one.
- R8: On a commit, `vramData` shows the strobed byte in the same cycle as `wrCommit`. On a drop, `vramData` keeps its value.
- R9: A dropped write restarts the spacing measurement just as a committed one does.
- R10: Spacing is the number of rising edges between the two strobe samples. Strobes on consecutive edges have spacing 1 and fall in the close class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per processor cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frameCycle | input | 17 | Cycles elapsed since the vertical interrupt |
| modeSel | input | 2 | Display mode; 2'b00 is text mode, other values are graphic modes |
| ntscSel | input | 1 | 1 selects the 60 Hz boundaries, 0 the 50 Hz ones |
| wrStrobe | input | 1 | One-cycle write strobe toward video memory |
| wrData | input | 8 | Byte carried by the strobe |
| wrCommit | output | 1 | Previous-edge strobe landed |
| wrDrop | output | 1 | Previous-edge strobe was lost |
| vramData | output | 8 | Last byte that landed |

## Verification
Every result here is due exactly one rising edge after the strobe that causes it. The flags and the data byte are registered together, and the spacing counter adds no further delay. The bench drives inputs on the falling edge. At the next falling edge it compares all three outputs with a behavioural model that holds the cycle of the last strobe as an integer. That comparison lands at the single edge where the design must have updated. Directed strobes sit one cycle either side of every boundary. They are placed at spacings of 1, 12, 18, 19, 24 and 25 cycles, and in one pair the spacing counted from a dropped write differs in class from the spacing counted from the last committed one.

// File: rtl/vwt_pkg.sv
package vwt_pkg;

  typedef enum logic [1:0] {
    GAP_CLOSE = 2'd0,
    GAP_WIDE  = 2'd1,
    GAP_LONG  = 2'd2
  } gapClass_t;

  typedef enum logic [1:0] {
    MODE_TEXT = 2'b00,
    MODE_GFX1 = 2'b01,
    MODE_GFX2 = 2'b10,
    MODE_GFX3 = 2'b11
  } dispMode_t;

  typedef struct packed {
    logic commit;
    logic drop;
  } wrStrobes_t;

endpackage

// File: rtl/vwt_gap_timer.sv
module vwt_gap_timer
  import vwt_pkg::*;
#(
  parameter int CLOSE_MAX = 18,
  parameter int WIDE_MAX  = 24
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wrStrobe,
  output gapClass_t gapClass
);
  localparam int GAP_CAP = WIDE_MAX + 1;
  localparam int GAP_W   = $clog2(GAP_CAP + 1);

  logic [GAP_W-1:0] gapCnt;

  // counts edges since the last strobe; saturates to mean "no recent write"
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gapCnt <= GAP_W'(GAP_CAP);
    end else if (wrStrobe) begin
      gapCnt <= GAP_W'(1);
    end else if (gapCnt != GAP_W'(GAP_CAP)) begin
      gapCnt <= gapCnt + GAP_W'(1);
    end
  end

  always_comb begin
    if (gapCnt > GAP_W'(WIDE_MAX))       gapClass = GAP_LONG;
    else if (gapCnt > GAP_W'(CLOSE_MAX)) gapClass = GAP_WIDE;
    else                                  gapClass = GAP_CLOSE;
  end

  p_gap_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gapCnt >= GAP_W'(1) && gapCnt <= GAP_W'(GAP_CAP));

  // R9: every strobe, committed or dropped, restarts the spacing
  p_gap_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrStrobe |=> gapClass == GAP_CLOSE);

endmodule

// File: rtl/vwt_control.sv
module vwt_control
  import vwt_pkg::*;
#(
  parameter int CYC_W      = 17,
  parameter int PAL_CLOSE  = 27130,
  parameter int PAL_WIDE   = 27143,
  parameter int NTSC_CLOSE = 15503,
  parameter int NTSC_WIDE  = 15517
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] frameCycle,
  input  logic [1:0]       modeSel,
  input  logic             ntscSel,
  input  logic             wrStrobe,
  input  gapClass_t        gapClass,
  output wrStrobes_t       strb
);
  localparam logic [CYC_W-1:0] B_PAL_CLOSE  = CYC_W'(PAL_CLOSE);
  localparam logic [CYC_W-1:0] B_PAL_WIDE   = CYC_W'(PAL_WIDE);
  localparam logic [CYC_W-1:0] B_NTSC_CLOSE = CYC_W'(NTSC_CLOSE);
  localparam logic [CYC_W-1:0] B_NTSC_WIDE  = CYC_W'(NTSC_WIDE);

  logic [CYC_W-1:0] failFrom;
  logic             textMode;
  logic             safeWrite;

  always_comb begin
    unique case ({ntscSel, gapClass == GAP_WIDE})
      2'b00:   failFrom = B_PAL_CLOSE;
      2'b01:   failFrom = B_PAL_WIDE;
      2'b10:   failFrom = B_NTSC_CLOSE;
      default: failFrom = B_NTSC_WIDE;
    endcase
  end

  assign textMode  = (dispMode_t'(modeSel) == MODE_TEXT);
  assign safeWrite = textMode || (gapClass == GAP_LONG) || (frameCycle < failFrom);

  assign strb.commit = wrStrobe & safeWrite;
  assign strb.drop   = wrStrobe & ~safeWrite;

  p_single_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.commit, strb.drop}) && ((strb.commit | strb.drop) == wrStrobe));

endmodule

// File: rtl/vwt_datapath.sv
module vwt_datapath
  import vwt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wrStrobes_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrCommit,
  output logic              wrDrop,
  output logic [DATA_W-1:0] vramData
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrCommit <= 1'b0;
      wrDrop   <= 1'b0;
      vramData <= '0;
    end else begin
      wrCommit <= strb.commit;
      wrDrop   <= strb.drop;
      if (strb.commit) vramData <= wrData;
    end
  end

  p_drop_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrDrop |-> $stable(vramData));

  p_commit_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrCommit |-> vramData == $past(wrData));

endmodule

// File: rtl/vram_write_window.sv
module vram_write_window
  import vwt_pkg::*;
#(
  parameter int CYC_W      = 17,
  parameter int DATA_W     = 8,
  parameter int CLOSE_MAX  = 18,
  parameter int WIDE_MAX   = 24,
  parameter int PAL_CLOSE  = 27130,
  parameter int PAL_WIDE   = 27143,
  parameter int NTSC_CLOSE = 15503,
  parameter int NTSC_WIDE  = 15517
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  frameCycle,
  input  logic [1:0]        modeSel,
  input  logic              ntscSel,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrCommit,
  output logic              wrDrop,
  output logic [DATA_W-1:0] vramData
);
  gapClass_t  gapClass;
  wrStrobes_t strb;

  vwt_gap_timer #(.CLOSE_MAX(CLOSE_MAX), .WIDE_MAX(WIDE_MAX)) u_gap (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .gapClass(gapClass)
  );

  vwt_control #(
    .CYC_W(CYC_W), .PAL_CLOSE(PAL_CLOSE), .PAL_WIDE(PAL_WIDE),
    .NTSC_CLOSE(NTSC_CLOSE), .NTSC_WIDE(NTSC_WIDE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameCycle(frameCycle), .modeSel(modeSel),
    .ntscSel(ntscSel), .wrStrobe(wrStrobe), .gapClass(gapClass), .strb(strb)
  );

  vwt_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData),
    .wrCommit(wrCommit), .wrDrop(wrDrop), .vramData(vramData)
  );

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrStrobe |=> !wrCommit && !wrDrop);

  p_text_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStrobe && modeSel == 2'b00) |=> wrCommit);

  p_pal_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStrobe && !ntscSel && frameCycle < CYC_W'(PAL_CLOSE)) |=> wrCommit);

  p_isolated_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStrobe && gapClass == GAP_LONG) |=> wrCommit);

endmodule

// File: tb/vram_write_window_bench.sv
`timescale 1ns/1ps
module vram_write_window_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] frameCycle = '0;
  logic [1:0]  modeSel = 2'b00;
  logic        ntscSel = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [7:0]  wrData = '0;
  logic        wrCommit, wrDrop;
  logic [7:0]  vramData;

  always #4 clk = ~clk;

  vram_write_window u_vram_write_window (
    .clk(clk), .rst_n(rst_n), .frameCycle(frameCycle), .modeSel(modeSel),
    .ntscSel(ntscSel), .wrStrobe(wrStrobe), .wrData(wrData),
    .wrCommit(wrCommit), .wrDrop(wrDrop), .vramData(vramData)
  );

  int         nChecks = 0;
  int         nFails  = 0;
  int         now     = 0;
  int         lastWr  = -1;
  logic       expCommit = 1'b0;
  logic       expDrop   = 1'b0;
  logic [7:0] expData   = '0;
  string      expTag    = "R1";
  string      note      = "";
  logic [7:0] seqByte   = 8'h10;

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: check the result of the previous cycle, then drive new inputs
  task automatic tick(input bit s, input logic [7:0] d, input int f,
                      input logic [1:0] m, input bit n);
    int gap;
    int bound;
    bit ok;
    @(negedge clk);
    check({expTag, note}, "wrCommit", int'(wrCommit), int'(expCommit));
    check({expTag, note}, "wrDrop", int'(wrDrop), int'(expDrop));
    check((expTag == "R1") ? "R1" : "R8", "vramData", int'(vramData), int'(expData));
    now++;
    wrStrobe   = s;
    wrData     = d;
    frameCycle = 17'(f);
    modeSel    = m;
    ntscSel    = n;
    if (s) begin
      gap = (lastWr < 0) ? 1000 : now - lastWr;
      if (n) bound = (gap <= 18) ? 15503 : 15517;
      else   bound = (gap <= 18) ? 27130 : 27143;
      ok = (m == 2'b00) || (gap > 24) || (f < bound);
      if (m == 2'b00)   expTag = "R3";
      else if (gap > 24) expTag = "R7";
      else if (gap < 12) expTag = "R10";
      else if (n)        expTag = "R6";
      else if (gap <= 18) expTag = "R4";
      else               expTag = "R5";
      lastWr    = now;
      expCommit = ok;
      expDrop   = !ok;
      if (ok) expData = d;
    end else begin
      expCommit = 1'b0;
      expDrop   = 1'b0;
      expTag    = "R2";
    end
  endtask

  // strobe 'spacing' edges after the previous one
  task automatic wr(input int spacing, input int f, input logic [1:0] m, input bit n);
    for (int i = 1; i < spacing; i++) tick(1'b0, 8'h00, f, m, n);
    seqByte = seqByte + 8'h0b;
    tick(1'b1, seqByte, f, m, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "wrCommit in reset", int'(wrCommit), 0);
    check("R1", "wrDrop in reset", int'(wrDrop), 0);
    check("R1", "vramData in reset", int'(vramData), 0);
    rst_n = 1'b1;

    // R7: first write after reset, late in frame, graphic mode
    wr(3, 60000, 2'b01, 1'b0);
    // R4: close spacing around 27130
    wr(12, 27129, 2'b01, 1'b0);
    wr(12, 27130, 2'b01, 1'b0);
    wr(18, 27142, 2'b10, 1'b0);
    // R5: wide spacing around 27143
    wr(19, 27142, 2'b10, 1'b0);
    wr(24, 27143, 2'b11, 1'b0);
    // R7: gap beyond 24
    wr(25, 70000, 2'b11, 1'b0);
    // R3: text mode, close spacing, late frame
    wr(12, 60000, 2'b00, 1'b0);
    wr(1, 71000, 2'b00, 1'b0);
    // R6: 60 Hz boundaries
    wr(12, 15502, 2'b01, 1'b1);
    wr(12, 15503, 2'b01, 1'b1);
    wr(20, 15516, 2'b01, 1'b1);
    wr(20, 15517, 2'b01, 1'b1);
    // R9: spacing counted from a dropped write
    note = " R9";
    wr(30, 100, 2'b01, 1'b0);
    wr(12, 27135, 2'b01, 1'b0);
    wr(12, 27135, 2'b01, 1'b0);
    note = "";
    // R10: back-to-back strobes
    wr(30, 27140, 2'b01, 1'b0);
    wr(1, 27140, 2'b01, 1'b0);
    wr(1, 100, 2'b01, 1'b0);

    // mixed traffic near the boundaries
    for (int k = 0; k < 600; k++) begin
      int sp;
      int base;
      int fr;
      bit nt;
      sp   = $urandom_range(1, 28);
      nt   = 1'($urandom_range(0, 1));
      base = nt ? 15510 : 27136;
      fr   = base + $urandom_range(0, 20) - 10;
      wr(sp, fr, 2'($urandom_range(0, 3)), nt);
    end
    tick(1'b0, 8'h00, 0, 2'b01, 1'b0);
    tick(1'b0, 8'h00, 0, 2'b01, 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule